// File: doc/BRIEF.md
# Parallel EEPROM Page Load and Commit Engine

This block sits on the device side of a byte-wide parallel memory bus. The bus carries active-low chip enable, write enable and output enable strobes, a 15-bit address and an 8-bit data bus, and all of it is already synchronous to the system clock. A falling write strobe with chip enable low is one byte load. Each load places its data in a 64-byte staging buffer at the offset given by the six low address bits, and marks that slot as filled. The loads may arrive in any order and may repeat an offset.

A cycle counter restarts at every rising edge of write enable. When write enable stays high long enough for the counter to reach the byte-load limit, the block commits the staged bytes to its backing array as a single program cycle. Only the filled slots are written, into the page named by the most recent load. During the program time the block raises `busy` and ignores new write strobes. When the program time ends, the fill marks are cleared.

A read takes place when chip enable and output enable are low and write enable is high. The read returns the stored byte at the addressed location and raises `dout_oe`, which enables an external tri-state pad driver.

Top module: `epw_top`

## Requirements
- R1: After reset, `busy` is 0, `dout_oe` is 0 with the bus idle, and every byte of the backing array reads 8'hFF.
- R2: A byte load happens only on a clock where `we_n` was 1 on the previous clock, is 0 now, and `ce_n` is 0. A write strobe with `ce_n` high stores nothing.
- R3: `addr[5:0]` selects the byte offset within the page, and loads may come in any offset order. A commit writes only the offsets that were loaded, and the other bytes of the page keep their old values.
- R4: The target page is `addr[14:6]` of the last load before the commit. With `NUM_PAGES` pages, only the low `$clog2(NUM_PAGES)` bits of that field select the page, so higher page numbers alias onto lower ones.
- R5: When the same offset is loaded more than once in a sequence, the data of the most recent load is the one committed.
- R6: Loads spaced closer than `T_BLC` cycles never start a commit. `busy` rises on the clock edge `T_BLC` cycles after the clock that first sees `we_n` high again after a load, and it stays high for exactly `T_PROG` cycles.
- R7: Write strobes that arrive while `busy` is high are ignored. They store no data, and no second program cycle follows.
- R8: `dout_oe` is 1 exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1. In that case `dout` shows the stored byte at `addr`.
- R9: The fill marks clear when a program cycle ends, so a later sequence writes only its own offsets.
- R10: All 64 offsets can be loaded in one sequence, and the commit then rewrites the whole page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 15 | Byte address: page in bits 14..6, offset in bits 5..0 |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| dout_oe | output | 1 | Read data valid, enables the external pad driver |
| busy | output | 1 | High for the whole program cycle |

## Verification
The hardest situation to reach is a write strobe that arrives in the middle of a program cycle. It must leave no trace, neither in the array nor as a second commit once `busy` drops. The bench reaches this by counting clocks from the last write-enable rise and injecting a strobe a few cycles after `busy` is expected to rise. It then watches for a window longer than the byte-load limit and reads the poked location back. A second hard case is a page switch in the middle of a sequence, together with page-number aliasing. Directed sequences first load bytes with one page number, then finish with another or with a number above the array size. Random sequences with short load gaps mix offsets, repeats and pages against a bench model of the array.

// File: rtl/epw_pkg.sv
// Shared constants and types for the page-load/commit engine.
// Assumes a fixed 64-byte page and a 15-bit byte address.
package epw_pkg;
    localparam int ADDR_W      = 15;
    localparam int DATA_W      = 8;
    localparam int OFF_W       = 6;
    localparam int PAGE_BYTES  = 1 << OFF_W;
    localparam int PAGE_ADDR_W = ADDR_W - OFF_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } epw_state_t;
endpackage

// File: rtl/epw_bus_sampler.sv
// Detects write-strobe edges on the synchronous bus.
// Assumes the strobes are already synchronous to clk; keeps one cycle of
// write-enable history. A load is a CE-qualified falling WE while not busy.
module epw_bus_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic busy,
    output logic load_stb,
    output logic rise_stb,
    output logic hold_hi
);
    logic we_q;

    // Remember last sampled write-enable level.
    always_ff @(posedge clk) begin
        if (!rst_n) we_q <= 1'b1;
        else        we_q <= we_n;
    end

    assign load_stb = we_q & ~we_n & ~ce_n & ~busy;
    assign rise_stb = ~we_q & we_n;
    assign hold_hi  = we_q & we_n;
endmodule

// File: rtl/epw_page_buffer.sv
// 64-slot staging buffer with per-slot fill marks and a page latch.
// Assumes load and clear never coincide (loads are blocked while busy).
module epw_page_buffer
    import epw_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            load,
    input  logic                            clr,
    input  logic [OFF_W-1:0]                off,
    input  logic [PAGE_ADDR_W-1:0]          page_in,
    input  logic [DATA_W-1:0]               din,
    output logic [PAGE_BYTES*DATA_W-1:0]    data_o,
    output logic [PAGE_BYTES-1:0]           mask_o,
    output logic [PAGE_ADDR_W-1:0]          page_o
);
    logic [PAGE_ADDR_W-1:0] page_q;

    // Page number follows the most recent load.
    always_ff @(posedge clk) begin
        if (!rst_n)    page_q <= '0;
        else if (load) page_q <= page_in;
    end
    assign page_o = page_q;

    for (genvar o = 0; o < PAGE_BYTES; o++) begin : g_slot
        logic [DATA_W-1:0] byte_q;
        logic              fill_q;
        logic              hit;

        assign hit = load && (off == OFF_W'(o));

        // Slot data: newest load to this offset wins.
        always_ff @(posedge clk) begin
            if (!rst_n)   byte_q <= '0;
            else if (hit) byte_q <= din;
        end

        // Fill mark: set by a load, cleared when programming ends.
        always_ff @(posedge clk) begin
            if (!rst_n)   fill_q <= 1'b0;
            else if (clr) fill_q <= 1'b0;
            else if (hit) fill_q <= 1'b1;
        end

        assign data_o[o*DATA_W +: DATA_W] = byte_q;
        assign mask_o[o] = fill_q;
    end
endmodule

// File: rtl/epw_seq.sv
// Load-window timer and program-cycle sequencer.
// Assumes T_BLC >= 1 and T_PROG >= 1. A commit fires when WE has been high
// T_BLC cycles after its rise; busy then lasts T_PROG cycles.
module epw_seq
    import epw_pkg::*;
#(
    parameter int T_BLC  = 8,
    parameter int T_PROG = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_stb,
    input  logic rise_stb,
    input  logic hold_hi,
    output logic commit,
    output logic clr,
    output logic busy
);
    localparam int CNT_W  = $clog2(T_BLC + 1);
    localparam int PCNT_W = $clog2(T_PROG + 1);
    localparam logic [CNT_W-1:0]  BLC_LAST  = CNT_W'(T_BLC - 1);
    localparam logic [PCNT_W-1:0] PROG_LAST = PCNT_W'(T_PROG - 1);

    epw_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [PCNT_W-1:0] pcnt_q, pcnt_d;

    // Next-state logic for load window and program timing.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        pcnt_d  = pcnt_q;
        commit  = 1'b0;
        clr     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (load_stb) begin
                    state_d = ST_LOAD;
                    cnt_d   = '0;
                end
            end
            ST_LOAD: begin
                if (load_stb || rise_stb) begin
                    cnt_d = '0;
                end else if (hold_hi) begin
                    if (cnt_q == BLC_LAST) begin
                        state_d = ST_PROG;
                        commit  = 1'b1;
                        pcnt_d  = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_PROG: begin
                if (pcnt_q == PROG_LAST) begin
                    state_d = ST_IDLE;
                    clr     = 1'b1;
                end else begin
                    pcnt_d = pcnt_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            pcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pcnt_q  <= pcnt_d;
        end
    end

    assign busy = (state_q == ST_PROG);
endmodule

// File: rtl/epw_array.sv
// Backing byte array of NUM_PAGES pages with masked page commit.
// Assumes NUM_PAGES is a power of two >= 2; reset models erased cells (FF).
module epw_array
    import epw_pkg::*;
#(
    parameter int NUM_PAGES = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         commit,
    input  logic [$clog2(NUM_PAGES)-1:0] wr_page,
    input  logic [PAGE_BYTES*DATA_W-1:0] wr_data,
    input  logic [PAGE_BYTES-1:0]        wr_mask,
    input  logic [$clog2(NUM_PAGES)-1:0] rd_page,
    input  logic [OFF_W-1:0]             rd_off,
    output logic [DATA_W-1:0]            rd_data
);
    localparam int PAGE_W    = $clog2(NUM_PAGES);
    localparam int NUM_BYTES = NUM_PAGES * PAGE_BYTES;
    localparam int IDX_W     = PAGE_W + OFF_W;

    logic [DATA_W-1:0] mem [NUM_BYTES];

    // Erase-then-write of the filled slots of the selected page.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (!rst_n) begin
                mem[i] <= '1;
            end else if (commit && (wr_page == PAGE_W'(i / PAGE_BYTES))
                         && wr_mask[i % PAGE_BYTES]) begin
                mem[i] <= wr_data[(i % PAGE_BYTES)*DATA_W +: DATA_W];
            end
        end
    end

    logic [IDX_W-1:0] rd_idx;
    assign rd_idx  = {rd_page, rd_off};
    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/epw_top.sv
// Page-mode write engine top: bus sampling, staging, timing, array.
// Assumes all bus inputs are synchronous to clk; dout_oe drives an
// external tri-state pad.
module epw_top
    import epw_pkg::*;
#(
    parameter int T_BLC     = 8,
    parameter int T_PROG    = 20,
    parameter int NUM_PAGES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              busy
);
    localparam int PAGE_W = $clog2(NUM_PAGES);

    logic                         load_stb, rise_stb, hold_hi;
    logic                         commit, clr;
    logic [PAGE_BYTES*DATA_W-1:0] stage_data;
    logic [PAGE_BYTES-1:0]        stage_mask;
    logic [PAGE_ADDR_W-1:0]       stage_page;
    logic                         unused_page_hi;

    epw_bus_sampler u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .busy     (busy),
        .load_stb (load_stb),
        .rise_stb (rise_stb),
        .hold_hi  (hold_hi)
    );

    epw_page_buffer u_buffer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_stb),
        .clr     (clr),
        .off     (addr[OFF_W-1:0]),
        .page_in (addr[ADDR_W-1:OFF_W]),
        .din     (din),
        .data_o  (stage_data),
        .mask_o  (stage_mask),
        .page_o  (stage_page)
    );

    epw_seq #(.T_BLC(T_BLC), .T_PROG(T_PROG)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_stb (load_stb),
        .rise_stb (rise_stb),
        .hold_hi  (hold_hi),
        .commit   (commit),
        .clr      (clr),
        .busy     (busy)
    );

    epw_array #(.NUM_PAGES(NUM_PAGES)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .wr_page (stage_page[PAGE_W-1:0]),
        .wr_data (stage_data),
        .wr_mask (stage_mask),
        .rd_page (addr[OFF_W +: PAGE_W]),
        .rd_off  (addr[OFF_W-1:0]),
        .rd_data (dout)
    );

    // Page-number bits above the array size alias and are not decoded.
    assign unused_page_hi = ^{stage_page[PAGE_ADDR_W-1:PAGE_W], addr[ADDR_W-1:OFF_W+PAGE_W]};

    assign dout_oe = ~ce_n & ~oe_n & we_n;
endmodule

// File: rtl/epw_checker.sv
// Timing and output properties of epw_top, attached by bind.
// Assumes the same parameters as the bound instance.
module epw_checker #(
    parameter int T_BLC  = 8,
    parameter int T_PROG = 20
) (
    input logic        clk,
    input logic        rst_n,
    input logic        we_n,
    input logic [14:0] addr,
    input logic [7:0]  dout,
    input logic        dout_oe,
    input logic        busy
);
    localparam int HW = $clog2(T_BLC + 3);
    localparam int BW = $clog2(T_PROG + 2);

    logic [HW-1:0] hi_cnt;
    logic [BW-1:0] busy_len;

    // Cycles write enable has been sampled high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                        hi_cnt <= '0;
        else if (!we_n)                    hi_cnt <= '0;
        else if (hi_cnt != HW'(T_BLC + 2)) hi_cnt <= hi_cnt + 1'b1;
    end

    // Length of the current busy interval.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_len <= '0;
        else if (busy) busy_len <= busy_len + 1'b1;
        else           busy_len <= '0;
    end

    p_commit_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (hi_cnt == HW'(T_BLC + 1)));

    p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == BW'(T_PROG)));

    p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |=> !busy);

    p_no_drive_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !dout_oe);

    p_read_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && $past(dout_oe) && $stable(addr) && !busy && !$past(busy))
        |-> $stable(dout));
endmodule

bind epw_top epw_checker #(.T_BLC(T_BLC), .T_PROG(T_PROG)) u_epw_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_n    (we_n),
    .addr    (addr),
    .dout    (dout),
    .dout_oe (dout_oe),
    .busy    (busy)
);

// File: tb/epw_top_bench.sv
module epw_top_bench;
    localparam int T_BLC     = 8;
    localparam int T_PROG    = 20;
    localparam int NUM_PAGES = 4;
    localparam int NB        = NUM_PAGES * 64;

    logic        clk = 1'b0;
    logic        rst_n, ce_n, we_n, oe_n;
    logic [14:0] addr;
    logic [7:0]  din;
    logic [7:0]  dout;
    logic        dout_oe, busy;

    always #10 clk = ~clk;

    epw_top #(.T_BLC(T_BLC), .T_PROG(T_PROG), .NUM_PAGES(NUM_PAGES)) u_epw_top (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe), .busy(busy)
    );

    int          checks = 0;
    int          fails  = 0;
    logic [7:0]  model [NB];
    logic [7:0]  pend_d [64];
    bit          pend_v [64];
    int          pend_page = 0;

    function automatic int page_of(input logic [14:0] a);
        return int'(a[14:6]) % NUM_PAGES;
    endfunction

    function automatic bit exp_busy(input int k);
        return (k > T_BLC) && (k <= T_BLC + T_PROG);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One write strobe lasting one clock, then one clock high.
    task automatic wr(input logic [14:0] a, input logic [7:0] d, input bit ce_hi = 1'b0);
        @(negedge clk);
        ce_n = ce_hi; we_n = 1'b0; addr = a; din = d;
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        if (!ce_hi) begin
            pend_d[a[5:0]] = d;
            pend_v[a[5:0]] = 1'b1;
            pend_page = page_of(a);
        end
    endtask

    // Wait out the load limit and program time, checking busy each cycle.
    task automatic finish_seq(input bit poke);
        int bad = 0;
        for (int k = 1; k <= T_BLC + T_PROG + 1; k++) begin
            @(negedge clk);
            if (busy !== exp_busy(k)) bad++;
            if (poke && k == T_BLC + 3) begin
                ce_n = 1'b0; we_n = 1'b0; addr = 15'h0000; din = 8'h5A;
            end
            if (poke && k == T_BLC + 4) begin
                we_n = 1'b1; ce_n = 1'b1;
            end
        end
        chk(bad == 0, "R6 busy window", bad, 0);
        for (int i = 0; i < 64; i++) begin
            if (pend_v[i]) model[pend_page*64 + i] = pend_d[i];
            pend_v[i] = 1'b0;
        end
        if (poke) begin
            int seen = 0;
            for (int k = 0; k < 2*T_BLC + 4; k++) begin
                @(negedge clk);
                if (busy) seen++;
            end
            chk(seen == 0, "R7 no second program cycle", seen, 0);
        end
    endtask

    task automatic rd(input logic [14:0] a, input string req);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        #1;
        chk(dout_oe === 1'b1 && dout === model[page_of(a)*64 + int'(a[5:0])], req,
            int'(dout), int'(model[page_of(a)*64 + int'(a[5:0])]));
        oe_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic rd_page(input int p, input string req);
        int bad = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            ce_n = 1'b0; oe_n = 1'b0; addr = 15'(p*64 + i);
            #1;
            if (dout !== model[p*64 + i]) bad++;
        end
        oe_n = 1'b1; ce_n = 1'b1;
        chk(bad == 0, req, bad, 0);
    endtask

    // Watchdog: a hang counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hang expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NB; i++) model[i] = 8'hFF;
        for (int i = 0; i < 64; i++) pend_v[i] = 1'b0;
        rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = '0; din = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
        chk(dout_oe === 1'b0, "R1 no drive when idle", int'(dout_oe), 0);
        rd_page(2, "R1 erased page reads FF");

        // R3 R4 R5 R2 R8: out-of-order loads, repeat, page switch, ignored strobe
        wr(15'(3*64 + 5), 8'h11);
        wr(15'(3*64 + 2), 8'h22);
        wr(15'(1*64 + 9), 8'h77, 1'b1);           // R2 ce_n high: not stored
        wr(15'(3*64 + 63), 8'h33);
        wr(15'(1*64 + 2), 8'h44);                 // R5 repeat, R4 page now 1
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; addr = 15'(1*64 + 40); din = 8'h66;
        #1;
        chk(dout_oe === 1'b0, "R8 no drive while write strobe low", int'(dout_oe), 0);
        pend_d[40] = 8'h66; pend_v[40] = 1'b1; pend_page = 1;
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        finish_seq(1'b0);
        rd(15'(1*64 + 2), "R5 last data kept");
        rd(15'(1*64 + 9), "R2 ce_n high strobe ignored");
        rd_page(1, "R3 only loaded bytes written");
        rd_page(3, "R4 earlier page number not used");

        // R7 strobe during programming ignored
        wr(15'(0*64 + 7), 8'hA7);
        finish_seq(1'b1);
        rd(15'h0000, "R7 poked byte unchanged");
        rd(15'h0007, "R7 real load committed");

        // R9 second sequence on page 1 writes only its own slot
        wr(15'(1*64 + 5), 8'hC5);
        finish_seq(1'b0);
        rd_page(1, "R9 marks cleared between sequences");

        // R4 aliasing: page field 4+2 maps to page 2
        wr(15'(6*64 + 12), 8'hBE);
        finish_seq(1'b0);
        rd(15'(2*64 + 12), "R4 page alias");

        // R8 chip enable high blocks read drive
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1;
        #1;
        chk(dout_oe === 1'b0, "R8 no drive with ce_n high", int'(dout_oe), 0);
        oe_n = 1'b1;

        // R10 full page in shuffled order
        begin
            int ord [64];
            for (int i = 0; i < 64; i++) ord[i] = i;
            for (int i = 63; i > 0; i--) begin
                int j = int'($urandom_range(i, 0));
                int t = ord[i]; ord[i] = ord[j]; ord[j] = t;
            end
            for (int i = 0; i < 64; i++) wr(15'(0*64 + ord[i]), 8'($urandom));
            finish_seq(1'b0);
            rd_page(0, "R10 full page commit");
        end

        // R3 R4 R5 random sequences
        for (int s = 0; s < 12; s++) begin
            int n = int'($urandom_range(10, 1));
            for (int i = 0; i < n; i++)
                wr(15'($urandom_range(32767, 0)), 8'($urandom));
            finish_seq(1'b0);
            rd_page(pend_page, "R3 random sequence page");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule